// File: doc/BRIEF.md
# Sequential Integer Multiplier with High-Word Register

This block multiplies two 32-bit integers for a processor datapath and produces a 64-bit product. It takes one partial product per clock. After a start request the unit goes busy, performs 32 shift-and-add steps and raises a one-cycle done pulse. On that cycle the lower half of the product is on the destination-register write data and the upper half has been loaded into a dedicated high-word register. That register is shared with other instructions, so it also has its own external read and write ports.

Each operation selects signed (two's complement) or unsigned interpretation of both operands. It also selects whether the condition flags are updated. Signed products are formed from operand magnitudes, and the sum is negated on the final step when the operand signs differ. When flags are updated, negative and zero describe the low word, and overflow and carry are cleared.

Top module: `imul_hiword`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `busy`, `done`, `flag_we`, `hi_q` and all four flags are 0.
- R2: With `is_signed`=0 both operands are unsigned. On the done cycle `lo_result` holds product bits 31:0 and `hi_q` holds bits 63:32 of the exact 64-bit product.
- R3: With `is_signed`=1 both operands are two's complement and `{hi_q, lo_result}` is the exact signed 64-bit product. This includes 0x80000000 × 0x80000000 = 0x4000000000000000 and −1 × −1 = 1.
- R4: A start request taken while idle raises `busy` at the next edge. `done` is high for exactly one cycle, 32 clock edges after the accepting edge, and `busy` is low on that cycle. A new start may be accepted on the done cycle.
- R5: `start` is ignored while `busy` is high. It produces no extra done pulse and does not change the operation in progress.
- R6: With `set_cc`=1, `flag_we` is high on the done cycle. At the same time `flag_n` = bit 31 of the low word, `flag_z` = (low word == 0), and `flag_v` = `flag_c` = 0.
- R7: With `set_cc`=0, `flag_we` stays low and all four stored flags keep their previous values.
- R8: When `hi_wr_en` is high at a clock edge that does not complete a multiply, `hi_q` shows `hi_wr_data` after that edge. With no write and no completion, `hi_q` holds its value.
- R9: If `hi_wr_en` is high at the edge that completes a multiply, the product's high word is stored and the external data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| set_cc | input | 1 | 1: update condition flags on completion |
| hi_wr_en | input | 1 | External write enable for the high-word register |
| hi_wr_data | input | 32 | External write data for the high-word register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| lo_result | output | 32 | Product bits 31:0 for the destination register |
| hi_q | output | 32 | High-word register contents |
| flag_we | output | 1 | Flag write enable, pulses with done when flags update |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |

## Verification
A product, its high word and its flags are all due on the cycle after the 32nd edge following the edge that accepts `start`. An external high-word write is visible one edge after it is presented. The driver stamps each expected item with its due cycle, which is the accepting edge plus 32. The monitor samples on falling edges and requires each done pulse to arrive exactly on its stamped cycle before it compares the product and flags. The clash case drives the external write in the cycle just before completion, so that it meets the product at the same edge.

// File: rtl/imul_pkg.sv
package imul_pkg;
  parameter int unsigned IMUL_XLEN = 32;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } imul_flags_t;
endpackage

// File: rtl/imul_seq.sv
module imul_seq #(
  parameter int unsigned STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last,
  output logic done
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q;

  assign load = start & ~busy_q;
  assign last = busy_q & (cnt_q == LAST_STEP);
  assign busy = busy_q;
  assign done = done_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= last;
    end
  end
endmodule

// File: rtl/imul_shift_add.sv
module imul_shift_add #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step_en,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sgn,
  output logic [2*XLEN-1:0] result
);
  localparam int unsigned PW = 2 * XLEN;

  logic [PW-1:0]   prod_q, mcand_q;
  logic [XLEN-1:0] mq_q;
  logic            neg_q;
  logic [XLEN-1:0] mag_a, mag_b;
  logic [PW-1:0]   prod_sum;

  // operand magnitudes; the most negative value maps to 2^(XLEN-1) unsigned
  assign mag_a = (sgn & a[XLEN-1]) ? (~a + 1'b1) : a;
  assign mag_b = (sgn & b[XLEN-1]) ? (~b + 1'b1) : b;

  assign prod_sum = prod_q + (mq_q[0] ? mcand_q : '0);
  assign result   = neg_q ? (~prod_sum + 1'b1) : prod_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
      mq_q    <= '0;
      neg_q   <= 1'b0;
    end else if (load) begin
      prod_q  <= '0;
      mcand_q <= {{XLEN{1'b0}}, mag_a};
      mq_q    <= mag_b;
      neg_q   <= sgn & (a[XLEN-1] ^ b[XLEN-1]);
    end else if (step_en) begin
      prod_q  <= prod_sum;
      mcand_q <= mcand_q << 1;
      mq_q    <= mq_q >> 1;
    end
  end
endmodule

// File: rtl/imul_hiword.sv
module imul_hiword
  import imul_pkg::*;
#(
  parameter int unsigned XLEN = IMUL_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            is_signed,
  input  logic            set_cc,
  input  logic            hi_wr_en,
  input  logic [XLEN-1:0] hi_wr_data,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] lo_result,
  output logic [XLEN-1:0] hi_q,
  output logic            flag_we,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  logic            load, last;
  logic [2*XLEN-1:0] result;

  logic [XLEN-1:0] lo_q, lo_d;
  logic [XLEN-1:0] hi_rq, hi_d;
  logic            cc_q, cc_d;
  imul_flags_t     flg_q, flg_d;
  logic            fwe_q, fwe_d;

  imul_seq #(.STEPS(XLEN)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .load  (load),
    .last  (last),
    .done  (done)
  );

  imul_shift_add #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step_en (busy),
    .a       (op_a),
    .b       (op_b),
    .sgn     (is_signed),
    .result  (result)
  );

  // next-state
  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_rq;
    cc_d  = cc_q;
    flg_d = flg_q;
    fwe_d = last & cc_q;
    if (load) cc_d = set_cc;
    if (last) begin
      lo_d = result[XLEN-1:0];
      hi_d = result[2*XLEN-1:XLEN];       // product wins over external write
      if (cc_q) begin
        flg_d.n = result[XLEN-1];
        flg_d.z = (result[XLEN-1:0] == '0);
        flg_d.v = 1'b0;
        flg_d.c = 1'b0;
      end
    end else if (hi_wr_en) begin
      hi_d = hi_wr_data;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_rq <= '0;
      cc_q  <= 1'b0;
      flg_q <= '0;
      fwe_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_rq <= hi_d;
      cc_q  <= cc_d;
      flg_q <= flg_d;
      fwe_q <= fwe_d;
    end
  end

  assign lo_result = lo_q;
  assign hi_q      = hi_rq;
  assign flag_we   = fwe_q;
  assign flag_n    = flg_q.n;
  assign flag_z    = flg_q.z;
  assign flag_v    = flg_q.v;
  assign flag_c    = flg_q.c;
endmodule

// File: rtl/imul_hiword_chk.sv
module imul_hiword_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] lo_result,
  input logic [XLEN-1:0] hi_q,
  input logic            hi_wr_en,
  input logic [XLEN-1:0] hi_wr_data,
  input logic            flag_we,
  input logic            flag_n,
  input logic            flag_z,
  input logic            flag_v,
  input logic            flag_c
);
  localparam int unsigned BW = $clog2(XLEN) + 2;
  logic [BW-1:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cycles <= '0;
    else if (busy) busy_cycles <= busy_cycles + 1'b1;
    else           busy_cycles <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> !busy && !done && !flag_we);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy_cycles == BW'(XLEN));
  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_cycles < BW'(XLEN));
  p_flag_we_r6: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> done);
  p_vc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> !flag_v && !flag_c);
  p_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_z == (lo_result == '0)) && (flag_n == lo_result[XLEN-1]));
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> $stable({flag_n, flag_z, flag_v, flag_c}));
  p_hi_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_en |=> done || (hi_q == $past(hi_wr_data)));
  p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr_en |=> done || $stable(hi_q));
endmodule

bind imul_hiword imul_hiword_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .lo_result  (lo_result),
  .hi_q       (hi_q),
  .hi_wr_en   (hi_wr_en),
  .hi_wr_data (hi_wr_data),
  .flag_we    (flag_we),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_v     (flag_v),
  .flag_c     (flag_c)
);

// File: tb/sim_imul_hiword.sv
module sim_imul_hiword;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        is_signed = 1'b0, set_cc = 1'b0;
  logic        hi_wr_en = 1'b0;
  logic [31:0] hi_wr_data = '0;
  logic        busy, done, flag_we, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] lo_result, hi_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  imul_hiword u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .set_cc(set_cc), .hi_wr_en(hi_wr_en),
    .hi_wr_data(hi_wr_data), .busy(busy), .done(done), .lo_result(lo_result),
    .hi_q(hi_q), .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct {
    logic [63:0] prod;
    logic        cc;
    int          due;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [3:0] exp_flags = 4'b0;   // {n,z,v,c}

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
    longint sa, sb;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // driver: start at a falling edge, push expected item
  task automatic do_mul(input logic [31:0] a, input logic [31:0] b, input logic s, input logic cc);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; is_signed = s; set_cc = cc; start = 1'b1;
    it.prod = ref_prod(a, b, s);
    it.cc   = cc;
    it.due  = cyc + 1 + LAT;
    q.push_back(it);
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        item_t it;
        n_done++;
        if (q.size() == 0) begin
          chk(1'b0, "R5 unexpected done", 64'(lo_result), 64'hx);
        end else begin
          it = q.pop_front();
          chk(cyc == it.due, "R4 done latency", 64'(cyc), 64'(it.due));
          chk(!busy, "R4 busy low on done", 64'(busy), 64'd0);
          chk({hi_q, lo_result} == it.prod, "R2/R3 product {hi,lo}", {hi_q, lo_result}, it.prod);
          if (it.cc) begin
            exp_flags = {it.prod[31], it.prod[31:0] == 32'b0, 1'b0, 1'b0};
            chk(flag_we, "R6 flag_we", 64'(flag_we), 64'd1);
            chk({flag_n, flag_z, flag_v, flag_c} == exp_flags, "R6 flags",
                64'({flag_n, flag_z, flag_v, flag_c}), 64'(exp_flags));
          end else begin
            chk(!flag_we, "R7 flag_we low", 64'(flag_we), 64'd0);
            chk({flag_n, flag_z, flag_v, flag_c} == exp_flags, "R7 flags kept",
                64'({flag_n, flag_z, flag_v, flag_c}), 64'(exp_flags));
          end
          @(negedge clk);
          chk(!done, "R4 done one cycle", 64'(done), 64'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dones_before;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !flag_we && hi_q == 0 && {flag_n, flag_z, flag_v, flag_c} == 0,
        "R1 reset state", {32'(busy), hi_q}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && hi_q == 0, "R1 after release", 64'(hi_q), 64'd0);

    // R2 unsigned products
    do_mul(32'd7, 32'd6, 1'b0, 1'b1);
    do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
    do_mul(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    do_mul(32'h0, 32'h1234_5678, 1'b0, 1'b1);       // zero flag
    // R3 signed products
    do_mul(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);
    do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    do_mul(32'hFFFF_FFFD, 32'd5, 1'b1, 1'b1);         // negative result
    do_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0); // R7: flags kept
    do_mul(32'd12345, 32'hFFFF_0000, 1'b1, 1'b0);
    wait_idle();

    // R5: start pulses during busy are ignored
    dones_before = n_done;
    do_mul(32'd3, 32'd9, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; is_signed = 1'b1; set_cc = 1'b0; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (LAT + 4) @(negedge clk);
    chk(n_done == dones_before + 1, "R5 single done", 64'(n_done - dones_before), 64'd1);

    // R8: external write while idle
    @(negedge clk);
    hi_wr_en = 1'b1; hi_wr_data = 32'hCAFE_F00D;
    @(negedge clk);
    hi_wr_en = 1'b0;
    chk(hi_q == 32'hCAFE_F00D, "R8 hi write", 64'(hi_q), 64'hCAFE_F00D);
    repeat (2) @(negedge clk);
    chk(hi_q == 32'hCAFE_F00D, "R8 hi hold", 64'(hi_q), 64'hCAFE_F00D);

    // R9: external write at the completing edge loses
    do_mul(32'h0001_0000, 32'h0003_0000, 1'b0, 1'b0);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    hi_wr_en = 1'b1; hi_wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    hi_wr_en = 1'b0;
    chk(hi_q == 32'h0000_0003, "R9 product beats write", 64'(hi_q), 64'h3);
    wait_idle();

    chk(q.size() == 0, "R4 all results delivered", 64'(q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule